// File: doc/BRIEF.md
# Secondary Bus Arbiter

This block decides which of nine downstream masters may use the secondary bus. Each master asks through an active-low request line and is answered on its own active-low grant line. The block watches the bus frame and initiator-ready lines to tell when the bus is idle. A grant goes out only at a safe moment, and a grant that has been removed is held off for a minimum number of clocks before that master can get it again. Requests are served in round-robin order, starting from the port after the last one granted.

When no master holds a grant and the bus is idle, the block raises `park_o`. This tells the bridge data path to drive the address/data, command/byte-enable and parity lines itself, which is known as bus parking.

A static strap input selects the mode. With the strap low, the internal arbiter runs. With the strap high, the block runs under an arbiter elsewhere on the bus. Request line 0 then carries the grant coming in to the bridge, and grant line 0 carries the bridge's own request going out. Ports 1 to 8 are left idle in this mode.

The internal arbiter has four states:
- `ST_PARK`: no grant is active.
- `ST_GRANT`: a grant is out, and its owner has not yet started.
- `ST_BUSY`: the owner's transaction is running.
- `ST_EXT`: strap mode.

The state transitions are:
- PARK to GRANT: the bus is idle and an eligible request exists.
- GRANT to BUSY: frame is sampled low.
- GRANT to PARK: the owner withdraws its request while frame is high.
- BUSY to GRANT: the handoff when frame is sampled high and another eligible request exists.
- BUSY to PARK: frame is sampled high and no other eligible request exists.
- Any state to EXT: the strap is high.
- EXT to PARK: the strap is low.

Top module: `sec_bus_arbiter`

## Requirements
- R1: With the strap low, at most one bit of `gnt_n` is low in any clock.
- R2: Once a grant bit returns high, it stays high for at least MIN_OFF (2) clocks before it may go low again.
- R3: In the park state with the bus idle, the next clock edge grants the first requesting port found by counting upward from the last granted port, wrapping from 8 to 0. After reset, the search starts at port 0.
- R4: A grant is given only at an edge where `frame_n` is high. From the park state, `irdy_n` must also be high (bus idle). While the bus is busy, requests are not granted.
- R5: While the owner's transaction runs, its grant is kept. At the edge where `frame_n` is sampled high again, the owner's grant is removed. At that same edge, the next requesting port after the owner (the owner excluded) is granted, if there is one.
- R6: A granted port whose request is high while `frame_n` is high loses its grant at the next edge.
- R7: With the strap low, `park_o` is high exactly when the arbiter is in the park state (no grant) and both `frame_n` and `irdy_n` are high.
- R8: With the strap high:
  - `gnt_n[8:1]` stay high and `req_n[8:1]` are ignored.
  - `gnt_n[0]` equals the inverse of `bridge_req`.
  - `park_o` equals (`req_n[0]` low, `frame_n` high and `irdy_n` high).
- R9: While `rst_n` is low, all grant bits are high and `park_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst_n | input | 1 | Secondary reset, active low, asynchronous |
| ext_arb_strap | input | 1 | High selects external-arbiter mode |
| req_n | input | 9 | Active-low requests. Bit 0 is the incoming grant in strap mode |
| frame_n | input | 1 | Bus frame, active low |
| irdy_n | input | 1 | Bus initiator ready, active low |
| bridge_req | input | 1 | Bridge's own request, used in strap mode |
| gnt_n | output | 9 | Active-low grants. Bit 0 is the outgoing request in strap mode |
| park_o | output | 1 | Bridge must drive address, command and parity lines |

## Verification
Each grant decision is registered, so a grant change appears one clock edge after the inputs that cause it. The bench drives inputs on the falling edge and checks the grants on the next falling edge. A request presented in the clock after a grant drop is checked high at one edge and low at the second. `park_o` and the strap-mode port-0 paths are combinational, so they are checked in the same half cycle as the stimulus. The round-robin expectation is computed arithmetically in the bench for every non-empty request mask, first for the grant from park and then for the handoff.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,
        ST_GRANT = 2'd1,
        ST_BUSY  = 2'd2,
        ST_EXT   = 2'd3
    } arb_state_e;

endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
    parameter int NUM_PORTS = 9,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_PORTS-1:0] elig,
    input  logic [IDX_W-1:0]     last,
    output logic                 valid,
    output logic [IDX_W-1:0]     idx
);

    // Scan offsets from farthest to nearest so the nearest eligible port wins.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int off = NUM_PORTS; off >= 1; off--) begin
            int k;
            logic [IDX_W-1:0] kk;
            k = int'(last) + off;
            if (k >= NUM_PORTS) k = k - NUM_PORTS;
            kk = IDX_W'(k);
            if (elig[kk]) begin
                valid = 1'b1;
                idx   = kk;
            end
        end
    end

endmodule

// File: rtl/sba_holdoff.sv
module sba_holdoff #(
    parameter int MIN_OFF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    output logic blocked
);

    localparam int CW = (MIN_OFF > 1) ? $clog2(MIN_OFF) : 1;
    localparam logic [CW-1:0] LOAD = CW'(MIN_OFF - 1);

    logic [CW-1:0] cnt_q;

    // Dropped in cycle t: blocked until the decision at edge t+MIN_OFF.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (drop) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blocked = (cnt_q != '0);

endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter
    import sba_pkg::*;
#(
    parameter int NUM_PORTS = 9,
    parameter int MIN_OFF   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_arb_strap,
    input  logic [NUM_PORTS-1:0] req_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    input  logic                 bridge_req,
    output logic [NUM_PORTS-1:0] gnt_n,
    output logic                 park_o
);

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(NUM_PORTS - 1);

    arb_state_e             state_q, state_d;
    logic [NUM_PORTS-1:0]   gnt_q, gnt_d;
    logic [IDX_W-1:0]       last_q, last_d;
    logic [NUM_PORTS-1:0]   hold;
    logic [NUM_PORTS-1:0]   elig;
    logic [NUM_PORTS-1:0]   drop;
    logic                   pick_valid;
    logic [IDX_W-1:0]       pick_idx;
    logic                   bus_idle;

    assign bus_idle = frame_n & irdy_n;
    assign elig     = ~req_n & ~hold & ~gnt_q;
    assign drop     = gnt_q & ~gnt_d;

    sba_rr_pick #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_pick (
        .elig  (elig),
        .last  (last_q),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_hold
        sba_holdoff #(
            .MIN_OFF (MIN_OFF)
        ) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .drop    (drop[i]),
            .blocked (hold[i])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            gnt_q   <= '0;
            last_q  <= LAST_RST;
        end else begin
            state_q <= state_d;
            gnt_q   <= gnt_d;
            last_q  <= last_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        gnt_d   = gnt_q;
        last_d  = last_q;
        unique case (state_q)
            ST_PARK: begin
                if (ext_arb_strap) begin
                    state_d = ST_EXT;
                    gnt_d   = '0;
                end else if (bus_idle && pick_valid) begin
                    state_d           = ST_GRANT;
                    gnt_d             = '0;
                    gnt_d[pick_idx]   = 1'b1;
                    last_d            = pick_idx;
                end
            end
            ST_GRANT: begin
                if (ext_arb_strap) begin
                    state_d = ST_EXT;
                    gnt_d   = '0;
                end else if (!frame_n) begin
                    state_d = ST_BUSY;
                end else if (req_n[last_q]) begin
                    state_d = ST_PARK;
                    gnt_d   = '0;
                end
            end
            ST_BUSY: begin
                if (ext_arb_strap) begin
                    state_d = ST_EXT;
                    gnt_d   = '0;
                end else if (frame_n) begin
                    gnt_d = '0;
                    if (pick_valid) begin
                        state_d         = ST_GRANT;
                        gnt_d[pick_idx] = 1'b1;
                        last_d          = pick_idx;
                    end else begin
                        state_d = ST_PARK;
                    end
                end
            end
            ST_EXT: begin
                gnt_d = '0;
                if (!ext_arb_strap) state_d = ST_PARK;
            end
            default: begin
                state_d = ST_PARK;
                gnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        gnt_n = ~gnt_q;
        if (ext_arb_strap) begin
            gnt_n[0] = ~(bridge_req & rst_n);
            park_o   = rst_n & ~req_n[0] & bus_idle;
        end else begin
            park_o   = rst_n & (state_q == ST_PARK) & bus_idle;
        end
    end

endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
    parameter int NUM_PORTS = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ext_arb_strap,
    input logic [NUM_PORTS-1:0] req_n,
    input logic                 frame_n,
    input logic                 irdy_n,
    input logic [NUM_PORTS-1:0] gnt_n,
    input logic                 park_o
);

    // R1: single owner in internal mode
    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_arb_strap |-> $onehot0(~gnt_n));

    // R7: parking only on an idle bus with no internal grant
    a_r7_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
        park_o |-> (frame_n && irdy_n && (&gnt_n[NUM_PORTS-1:1])));

    // R8: strap mode leaves ports 1..N-1 ungranted
    a_r8_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_arb_strap && $past(ext_arb_strap)) |-> (&gnt_n[NUM_PORTS-1:1]));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        // R2: minimum off time of two clocks
        a_r2_min_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!ext_arb_strap && $rose(gnt_n[i])) |=> (ext_arb_strap || gnt_n[i]));

        // R4: grants start only where frame was high
        a_r4_grant_frame: assert property (@(posedge clk) disable iff (!rst_n)
            (!ext_arb_strap && !$past(ext_arb_strap) && $fell(gnt_n[i])) |-> $past(frame_n));

        // R6: withdrawn request loses its grant next clock
        a_r6_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
            (!ext_arb_strap && !gnt_n[i] && req_n[i] && frame_n) |=> (ext_arb_strap || gnt_n[i]));
    end

endmodule

bind sec_bus_arbiter sba_checker #(
    .NUM_PORTS (NUM_PORTS)
) u_sba_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_arb_strap (ext_arb_strap),
    .req_n         (req_n),
    .frame_n       (frame_n),
    .irdy_n        (irdy_n),
    .gnt_n         (gnt_n),
    .park_o        (park_o)
);

// File: tb/sec_bus_arbiter_test.sv
module sec_bus_arbiter_test;

    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ext_arb_strap;
    logic [N-1:0] req_n;
    logic         frame_n;
    logic         irdy_n;
    logic         bridge_req;
    logic [N-1:0] gnt_n;
    logic         park_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sec_bus_arbiter uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_arb_strap (ext_arb_strap),
        .req_n         (req_n),
        .frame_n       (frame_n),
        .irdy_n        (irdy_n),
        .bridge_req    (bridge_req),
        .gnt_n         (gnt_n),
        .park_o        (park_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic int rr_next(int last, logic [N-1:0] mask);
        for (int off = 1; off <= N; off++) begin
            int k;
            k = (last + off) % N;
            if (mask[k]) return k;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] gvec(int p);
        logic [N-1:0] v;
        v = '1;
        if (p >= 0) v[p] = 1'b0;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int last;
        rst_n = 1'b0; ext_arb_strap = 1'b0; req_n = '1;
        frame_n = 1'b1; irdy_n = 1'b1; bridge_req = 1'b0;
        step(); step();
        req_n = '0;
        step();
        chk("R9 grants off in reset", gnt_n, '1);
        chk("R9 park low in reset", {8'h0, park_o}, 9'd0);
        req_n = '1;
        rst_n = 1'b1;
        step();
        chk("R7 park after reset", {8'h0, park_o}, 9'd1);
        chk("R9 no grant after reset", gnt_n, '1);

        // R4: no grant while bus busy
        frame_n = 1'b0; req_n = gvec(3);
        step();
        chk("R4 busy frame no grant", gnt_n, '1);
        chk("R7 no park when busy", {8'h0, park_o}, 9'd0);
        frame_n = 1'b1; irdy_n = 1'b0;
        step();
        chk("R4 irdy busy no grant", gnt_n, '1);
        irdy_n = 1'b1;
        step();
        chk("R3 first grant to port 3", gnt_n, gvec(3));
        chk("R7 no park with grant", {8'h0, park_o}, 9'd0);
        req_n = '1;
        step();
        chk("R6 withdraw drops grant", gnt_n, '1);

        // R2: immediate re-request waits two clocks
        req_n = gvec(3);
        step();
        chk("R2 still off one clock", gnt_n, '1);
        step();
        chk("R2 regrant after two clocks", gnt_n, gvec(3));
        req_n = '1;
        step();
        chk("R6 withdraw again", gnt_n, '1);
        last = 3;
        step(); step();

        // R3/R5 sweep over every request mask
        for (int m = 1; m < (1 << N); m++) begin
            logic [N-1:0] mask;
            int e1, e2;
            mask = N'(m);
            req_n = ~mask;
            step();
            e1 = rr_next(last, mask);
            chk("R3 round robin from park", gnt_n, gvec(e1));
            checks++;
            if ($countones(~gnt_n) > 1) begin
                fails++;
                $display("FAIL R1 multiple grants actual=%b expected=onehot", gnt_n);
            end
            frame_n = 1'b0; irdy_n = 1'b0;
            step();
            chk("R5 grant held while busy", gnt_n, gvec(e1));
            frame_n = 1'b1;
            step();
            e2 = rr_next(e1, mask & ~(N'(1) << e1));
            chk("R5 handoff at last phase", gnt_n, gvec(e2));
            chk("R7 no park last phase", {8'h0, park_o}, 9'd0);
            req_n = '1; irdy_n = 1'b1;
            step();
            chk("R6 withdrawn handoff dropped", gnt_n, '1);
            chk("R7 park when idle", {8'h0, park_o}, 9'd1);
            last = (e2 < 0) ? e1 : e2;
            step(); step();
        end

        // R8: external arbiter mode
        rst_n = 1'b0; ext_arb_strap = 1'b1;
        step(); step();
        rst_n = 1'b1;
        step();
        for (int v = 0; v < 16; v++) begin
            logic [3:0] b;
            b = 4'(v);
            bridge_req = b[0];
            req_n      = {8'h00, b[1]};
            frame_n    = b[2];
            irdy_n     = b[3];
            step();
            chk("R8 ext grant pins", gnt_n, {8'hFF, ~b[0]});
            chk("R8 ext park", {8'h0, park_o}, {8'h0, (!b[1] && b[2] && b[3])});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule